// File: doc/BRIEF.md
# Sticky Defect Status Word with Selective Clear

This block keeps a word of sticky defect flags for path, line and remote-end conditions so that management software can inspect them. Each flag is driven by a live condition input. The flag sets as soon as its condition is seen high and then holds. A condition that lasts only one cycle is still recorded.

Software takes a snapshot of the word with a read strobe. It then clears flags with a clear strobe that carries a per-bit select mask. Only the selected flags are cleared. The usual practice is to clear exactly the bits that were just read. A condition that rises in the window between the read and the clear therefore survives to the next read. If a condition is active in the same cycle as a clear of its own flag, the flag stays set.

Some positions in the word are reserved. These always read as zero. The remote-end part of the word places a payload defect flag at bit 10 and a combined server defect flag at bit 8, with bit 9 reserved between them.

Top module: `sticky_status_word`

## Requirements
- R1: After reset every flag is zero and the read data output is zero.
- R2: A flag sets in the clock edge at which its condition input is high, and it stays set while no clear selects it, even after the condition drops.
- R3: A clear strobe with a mask resets exactly the flags whose mask bit is 1 and whose condition is low. Flags outside the mask are unchanged. A mask presented without the clear strobe has no effect.
- R4: When a flag's condition is high in the same cycle as a clear that selects it, the flag remains set.
- R5: An event that occurs after a read and before a clear whose mask equals the value that was read is still present on the next read.
- R6: Reserved positions read as zero and ignore both conditions and clears. The default reserved mask is 16'hF200, which covers bits 15 to 12 and bit 9.
- R7: A read strobe loads the read data output, one edge later, with the flag word as it stood before that edge. The output holds its value when no strobe is given, and reading never changes any flag.
- R8: Bit 10 holds the remote payload defect flag, bit 8 holds the remote server defect flag, and bit 9 always reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| cond_i | input | 16 | Live condition inputs, one per flag |
| rd_stb_i | input | 1 | Read strobe that captures the flag word |
| rd_data_o | output | 16 | Registered snapshot of the flag word |
| clr_stb_i | input | 1 | Clear strobe |
| clr_mask_i | input | 16 | Per-bit clear select, where 1 means clear that flag |

## Verification
The flags are tested with several kinds of condition input. A single-cycle pulse followed by idle cycles separates true latching from simple following of the input. Two flags set together, with only one of them cleared, show that the mask acts per bit. A clear mask given without its strobe confirms that the mask alone does nothing. A condition that coincides with its own clear tests the priority of set over clear. A pulse placed between a read and a clear of the read-back bits checks the race that the mask is meant to remove. An all-ones condition word exposes the reserved positions and the remote-end layout. A read in the same cycle as a new condition shows that the snapshot is taken from the word before that edge.

// File: rtl/sticky_status_pkg.sv
package sticky_status_pkg;
  localparam int unsigned SSW_WIDTH = 16;
  localparam logic [SSW_WIDTH-1:0] SSW_RSVD_DEFAULT = 16'hF200;
  localparam int unsigned FE_PAYLOAD_BIT = 10;
  localparam int unsigned FE_GAP_BIT     = 9;
  localparam int unsigned FE_SERVER_BIT  = 8;
endpackage

// File: rtl/ssw_rst_sync.sv
module ssw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ssw_flag_cell.sv
module ssw_flag_cell #(
  parameter bit RESERVED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic flag_o
);
  generate
    if (RESERVED) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^{clk, rst_n, cond_i, clr_i};
      assign flag_o = 1'b0;
    end else begin : g_live
      logic flag_q;
      logic flag_d;
      logic flag_en;

      // set wins: a high condition overrides a same-cycle clear
      always_comb begin
        flag_en = cond_i | clr_i;
        flag_d  = cond_i | (flag_q & ~clr_i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (flag_en) flag_q <= flag_d;
      end

      assign flag_o = flag_q;

      a_r2_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i |=> flag_o);
      a_r2_holds_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
      a_r3_selected_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cond_i) |=> !flag_o);
      a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && cond_i) |=> flag_o);
    end
  endgenerate
endmodule

// File: rtl/ssw_read_reg.sv
module ssw_read_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (rd_stb_i) snap_q <= word_i;
  end

  assign rd_data_o = snap_q;

  a_r7_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));
  a_r7_snapshot_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> (rd_data_o == $past(word_i)));
endmodule

// File: rtl/sticky_status_word.sv
module sticky_status_word #(
  parameter int unsigned WIDTH = sticky_status_pkg::SSW_WIDTH,
  parameter logic [WIDTH-1:0] RSVD_MASK = sticky_status_pkg::SSW_RSVD_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_i,
  input  logic             rd_stb_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             clr_stb_i,
  input  logic [WIDTH-1:0] clr_mask_i
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] clr_sel;
  logic [WIDTH-1:0] flags;

  ssw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    clr_sel = {WIDTH{clr_stb_i}} & clr_mask_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_flag
    ssw_flag_cell #(.RESERVED(RSVD_MASK[b])) u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .cond_i (cond_i[b]),
      .clr_i  (clr_sel[b]),
      .flag_o (flags[b])
    );
  end

  ssw_read_reg #(.WIDTH(WIDTH)) u_read (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_stb_i  (rd_stb_i),
    .word_i    (flags),
    .rd_data_o (rd_data_o)
  );

  a_r6_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data_o & RSVD_MASK) == '0);
  a_r7_read_no_side_effect: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb_i && !clr_stb_i && cond_i == '0) |=> (flags == $past(flags)));
endmodule

// File: tb/sticky_status_word_tb_top.sv
module sticky_status_word_tb_top;
  localparam logic [15:0] RSVD = 16'hF200;

  logic        clk;
  logic        rst_n;
  logic [15:0] cond;
  logic        rd_stb;
  logic [15:0] rd_data;
  logic        clr_stb;
  logic [15:0] clr_mask;

  int          n_checks;
  int          n_fail;
  logic [15:0] model;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] held;

  sticky_status_word dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond),
    .rd_stb_i   (rd_stb),
    .rd_data_o  (rd_data),
    .clr_stb_i  (clr_stb),
    .clr_mask_i (clr_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step(input logic [15:0] c, input bit rd, input bit cl,
                      input logic [15:0] m, input string tag);
    cond = c; rd_stb = rd; clr_stb = cl; clr_mask = m;
    @(posedge clk);
    if (rd) begin
      exp_q.push_back(model);
      tag_q.push_back(tag);
    end
    model = ((model & ~(cl ? m : 16'h0)) | c) & ~RSVD;
    @(negedge clk);
    cond = '0; rd_stb = 1'b0; clr_stb = 1'b0; clr_mask = '0;
  endtask

  task automatic check_now(input logic [15:0] exp, input string tag);
    n_checks++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  // monitor: compare captured snapshots in scoreboard order
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0; model = '0;
    cond = '0; rd_stb = 1'b0; clr_stb = 1'b0; clr_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step('0, 0, 0, '0, "idle");

    step('0, 1, 0, '0, "R1 reset zero");
    // R2 pulse latches and persists
    step(16'h0001, 0, 0, '0, "pulse");
    step('0, 0, 0, '0, "idle");
    step('0, 1, 0, '0, "R2 latched pulse");
    step('0, 1, 0, '0, "R2 still latched");
    // R3 per-bit clear
    step(16'h0008, 0, 0, '0, "pulse");
    step('0, 0, 1, 16'h0001, "clear bit0");
    step('0, 1, 0, '0, "R3 only masked bit cleared");
    step('0, 0, 0, 16'h0008, "mask without strobe");
    step('0, 1, 0, '0, "R3 mask alone ignored");
    // R4 set over clear
    step(16'h0020, 0, 1, 16'h0028, "set with clear");
    step('0, 1, 0, '0, "R4 set beats clear");
    // R5 read, event, clear of read-back bits
    step('0, 1, 0, '0, "R5 first read");
    step(16'h0010, 0, 0, '0, "event in window");
    step('0, 0, 1, 16'h0020, "clear read bits");
    step('0, 1, 0, '0, "R5 window event kept");
    // R6 reserved
    step(16'hFFFF, 0, 0, '0, "all conditions");
    step('0, 1, 0, '0, "R6 reserved read zero");
    step('0, 0, 1, 16'hFFFF, "clear all");
    step('0, 1, 0, '0, "R6 full clear");
    // R8 remote-end layout
    step(16'h0700, 0, 0, '0, "remote bits");
    step('0, 1, 0, '0, "R8 payload bit10 server bit8 gap bit9");
    // R7 snapshot timing, hold and no side effect
    step(16'h0001, 1, 0, '0, "R7 read sees pre-edge word");
    step('0, 1, 0, '0, "R7 new bit after edge");
    held = rd_data;
    step(16'h0002, 0, 0, '0, "cond without read");
    check_now(held, "R7 output holds without strobe");
    step('0, 1, 0, '0, "R7 read one");
    step('0, 1, 0, '0, "R7 read two unchanged");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule